// File: doc/BRIEF.md
# Serial Flash Continuous-Read Responder

This block is the device side of a serial flash that answers the two continuous main-array read commands. While chip select is low it takes in an opcode and a 24-bit address on the serial data input, most significant bit first. It then streams bytes from its internal array out of the serial data output, also most significant bit first. At the end of a page it moves on to the next page, and at the end of the array it returns to byte 0, with no gap in either case. The slow read command starts data right after the address. The fast read command first takes one dummy byte.

A parameter selects how the 24-bit address is read. In page/byte layout the array is made of 264-byte pages, addressed by a page number and a byte offset. In flat layout the pages are 256 bytes and the address is a plain binary byte index. The page count is a parameter, so the array can stay small for simulation. A simple synchronous write port loads the array.

The serial pins are sampled by the system clock through two-stage synchronisers. Each half period of the serial clock must therefore last at least six system clock cycles. The output is a data bit plus an enable; while the enable is low the pin is to be treated as high impedance.

Top module: `sflash_cread`

## Requirements
- R1: Opcode 0x03 (slow read) takes 24 address bits after the 8 opcode bits. The first data bit (bit 7 of the addressed byte) is driven after the serial-clock falling edge that follows the 32nd rising edge.
- R2: Opcode 0x0B (fast read) takes 8 further dummy bits after the address, whose values are ignored. The first data bit is driven after the falling edge that follows the 40th rising edge.
- R3: With PAGE264=1, address bits [20:9] form the page number, taken modulo PAGES, and bits [8:0] form the byte offset. The start index is page*264+offset, so an offset of 264 or more runs into the next page. Bits [23:21] are ignored.
- R4: With PAGE264=0, the address is a flat byte index taken from bits [19:0], modulo the array size of PAGES*256 bytes.
- R5: After the last byte of a page, output continues with byte 0 of the next page, with no extra serial clocks.
- R6: After the last byte of the array, output continues with byte 0 of page 0, with no extra serial clocks.
- R7: The output enable is low out of reset and while chip select is high. It falls within four system clock cycles after a high chip select reaches the block, at any point of a command. The next low period starts a new command.
- R8: After any opcode other than 0x03 or 0x0B, the output enable stays low until chip select goes high.
- R9: Input bits are taken on serial-clock rising edges. The output bit changes only after falling edges, and the output enable stays low during the opcode, address and dummy bits. Every byte is sent most significant bit first.
- R10: A write-port cycle with wr_en high stores wr_data at byte index wr_addr. Later reads return the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out |
| spi_so_oe | output | 1 | Output enable for spi_so; low means high impedance |
| wr_en | input | 1 | Array write strobe |
| wr_addr | input | ADDR_W | Array write byte index |
| wr_data | input | 8 | Array write byte |

## Verification
A wrong address cursor shows up as a wrong byte on the first data byte after the header. A wrong next-byte step shows up on the first byte past a page or array end, so reads are placed to straddle both boundaries in both layouts. A wrong phase counter moves the whole stream by whole bits or bytes, which shows in the first byte read. A stuck state shows as an output enable that stays high after deselect, or rises after a bad opcode, within a few system clocks.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam logic [7:0] OP_SLOW = 8'h03;
  localparam logic [7:0] OP_FAST = 8'h0B;

  typedef enum logic [1:0] {ST_HDR, ST_DUMMY, ST_DATA, ST_IGNORE} rd_state_e;

  function automatic int page_bytes(input bit layout264);
    return layout264 ? 264 : 256;
  endfunction
endpackage

// File: rtl/sfr_pin_sync.sv
module sfr_pin_sync (
  input  logic clk,
  input  logic rst,
  input  logic sck_i,
  input  logic cs_n_i,
  input  logic si_i,
  output logic sck_rise,
  output logic sck_fall,
  output logic sel,
  output logic si_s
);
  logic [2:0] sck_p;
  logic [1:0] cs_p;
  logic [1:0] si_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_p <= '0;
      cs_p  <= '1;
      si_p  <= '0;
    end else begin
      sck_p <= {sck_p[1:0], sck_i};
      cs_p  <= {cs_p[0], cs_n_i};
      si_p  <= {si_p[0], si_i};
    end
  end

  assign sck_rise = sck_p[1] & ~sck_p[2];
  assign sck_fall = ~sck_p[1] & sck_p[2];
  assign sel      = ~cs_p[1];
  assign si_s     = si_p[1];
endmodule

// File: rtl/sfr_addr_map.sv
module sfr_addr_map #(
  parameter bit PAGE264 = 1'b1,
  parameter int PAGES   = 4,
  parameter int ADDR_W  = 11
) (
  input  logic [23:0]       raw,
  output logic [ADDR_W-1:0] lin
);
  generate
    if (PAGE264) begin : g_paged
      localparam int PG_W = $clog2(PAGES);
      localparam logic [ADDR_W:0] PB  = (ADDR_W+1)'(264);
      localparam logic [ADDR_W:0] TOT = (ADDR_W+1)'(PAGES * 264);
      logic [ADDR_W:0] sum;
      logic unused_hi;
      assign unused_hi = ^raw[23:9+PG_W];
      always_comb begin
        sum = (ADDR_W+1)'(raw[9 +: PG_W]) * PB + (ADDR_W+1)'(raw[8:0]);
        lin = (sum >= TOT) ? ADDR_W'(sum - TOT) : ADDR_W'(sum);
      end
    end else begin : g_flat
      logic unused_hi;
      assign unused_hi = ^raw[23:ADDR_W];
      assign lin = raw[ADDR_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/sfr_array.sv
module sfr_array #(
  parameter int DEPTH  = 1056,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic [7:0]        wd,
  input  logic [ADDR_W-1:0] ra,
  output logic [7:0]        rq
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && ({1'b0, wa} < (ADDR_W+1)'(DEPTH))) mem[wa] <= wd;
    rq <= mem[ra];
  end
endmodule

// File: rtl/sflash_cread.sv
module sflash_cread #(
  parameter bit PAGE264 = 1'b1,
  parameter int PAGES   = 4,
  parameter int ADDR_W  = $clog2(PAGES * (PAGE264 ? 264 : 256))
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_si,
  output logic              spi_so,
  output logic              spi_so_oe,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data
);
  import sfr_pkg::*;

  localparam int TOTAL = PAGES * page_bytes(PAGE264);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(TOTAL - 1);

  logic sck_rise, sck_fall, sel, si_s;
  logic [22:0] sr;
  logic [23:0] sr_next;
  logic [4:0]  hdr_cnt;
  logic [2:0]  bit_idx;
  logic [7:0]  op;
  logic [ADDR_W-1:0] cur, lin_start;
  logic [7:0]  rd_q;
  rd_state_e   st;

  sfr_pin_sync u_sync (
    .clk(clk), .rst(rst), .sck_i(spi_sck), .cs_n_i(spi_cs_n), .si_i(spi_si),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .sel(sel), .si_s(si_s)
  );

  assign sr_next = {sr, si_s};

  sfr_addr_map #(.PAGE264(PAGE264), .PAGES(PAGES), .ADDR_W(ADDR_W)) u_map (
    .raw(sr_next), .lin(lin_start)
  );

  sfr_array #(.DEPTH(TOTAL), .ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .we(wr_en), .wa(wr_addr), .wd(wr_data), .ra(cur), .rq(rd_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_HDR;
      sr        <= '0;
      hdr_cnt   <= '0;
      bit_idx   <= '0;
      op        <= '0;
      cur       <= '0;
      spi_so    <= 1'b0;
      spi_so_oe <= 1'b0;
    end else if (!sel) begin
      st        <= ST_HDR;
      hdr_cnt   <= '0;
      bit_idx   <= '0;
      spi_so_oe <= 1'b0;
    end else begin
      if (sck_rise) begin
        unique case (st)
          ST_HDR: begin
            sr      <= sr_next[22:0];
            hdr_cnt <= hdr_cnt + 5'd1;
            if (hdr_cnt == 5'd7) begin
              op <= sr_next[7:0];
              if (sr_next[7:0] != OP_SLOW && sr_next[7:0] != OP_FAST) st <= ST_IGNORE;
            end
            if (hdr_cnt == 5'd31) begin
              cur     <= lin_start;
              bit_idx <= '0;
              st      <= (op == OP_FAST) ? ST_DUMMY : ST_DATA;
            end
          end
          ST_DUMMY: begin
            bit_idx <= bit_idx + 3'd1;
            if (bit_idx == 3'd7) st <= ST_DATA;
          end
          ST_DATA: begin
            bit_idx <= bit_idx + 3'd1;
            if (bit_idx == 3'd7) cur <= (cur == LAST) ? '0 : cur + 1'b1;
          end
          default: ;
        endcase
      end
      if (sck_fall && st == ST_DATA) begin
        spi_so    <= rd_q[3'd7 - bit_idx];
        spi_so_oe <= 1'b1;
      end
    end
  end

  // R7: deselect forces high impedance
  a_r7_hiz_after_deselect: assert property (@(posedge clk) disable iff (rst)
    !sel |=> !spi_so_oe);
  // R8: an unknown opcode never drives the pin
  a_r8_ignore_silent: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IGNORE) |-> !spi_so_oe);
  // R2: dummy phase only for the fast opcode
  a_r2_dummy_only_fast: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DUMMY) |-> (op == OP_FAST));
  // R1: direct entry into data only for the slow opcode
  a_r1_slow_no_dummy: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DATA && $past(st) == ST_HDR) |-> (op == OP_SLOW));
  // R9: output bit moves only after a falling edge
  a_r9_so_on_fall_only: assert property (@(posedge clk) disable iff (rst)
    !sck_fall |=> $stable(spi_so));
  // R9: no drive while header bits are arriving
  a_r9_quiet_header: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HDR || st == ST_DUMMY) |-> !spi_so_oe);
  // R6: byte cursor stays inside the array
  a_r6_cursor_in_range: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, cur} < (ADDR_W+1)'(TOTAL)));
endmodule

// File: tb/tb_sflash_cread.sv
`timescale 1ns/1ps
module tb_sflash_cread;
  localparam int HALF  = 8;
  localparam int TOT_A = 1056;
  localparam int TOT_B = 1024;

  typedef struct packed {
    logic [7:0]  op;
    logic [23:0] addr;
    logic [3:0]  n;
    logic [10:0] start;
  } vec_t;

  // R1 R2 R3 R5 R6 vectors for the 264-byte layout
  localparam vec_t VECS [7] = '{
    '{8'h03, 24'h000205, 4'd4, 11'd269},   // R1 R3 page 1 byte 5
    '{8'h0B, 24'h000400, 4'd3, 11'd528},   // R2 page 2 byte 0
    '{8'h03, 24'h000106, 4'd4, 11'd262},   // R5 crosses page 0 -> 1
    '{8'h0B, 24'h000706, 4'd4, 11'd1054},  // R6 crosses array end
    '{8'h03, 24'h00012C, 4'd2, 11'd300},   // R3 offset >= 264
    '{8'h03, 24'h000A0A, 4'd2, 11'd274},   // R3 page modulo PAGES
    '{8'h0B, 24'hE00205, 4'd2, 11'd269}    // R3 upper bits ignored
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, si = 1'b0, cs_a = 1'b1, cs_b = 1'b1;
  logic so_a, oe_a, so_b, oe_b;
  logic we_a = 1'b0, we_b = 1'b0;
  logic [10:0] wa_a = '0;
  logic [9:0]  wa_b = '0;
  logic [7:0]  wd = '0;
  logic [7:0]  model_a [TOT_A];
  logic [7:0]  model_b [TOT_B];
  int checks = 0, fails = 0, sel = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sflash_cread dut (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_a), .spi_si(si),
    .spi_so(so_a), .spi_so_oe(oe_a), .wr_en(we_a), .wr_addr(wa_a), .wr_data(wd)
  );

  sflash_cread #(.PAGE264(1'b0), .PAGES(4)) dut256 (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_b), .spi_si(si),
    .spi_so(so_b), .spi_so_oe(oe_b), .wr_en(we_b), .wr_addr(wa_b), .wr_data(wd)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + (i >> 5) + 11) & 255);
  endfunction

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic spi_bit(input logic b, output logic s, output logic oe);
    si = b;
    repeat (HALF) @(negedge clk);
    s  = (sel != 0) ? so_b : so_a;
    oe = (sel != 0) ? oe_b : oe_a;
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic set_cs(input int which, input logic v);
    if (which != 0) cs_b = v; else cs_a = v;
  endtask

  task automatic do_read(input int which, input logic [7:0] op, input logic [23:0] addr,
                         input int n, input int start, input string tag);
    logic s, oe, quiet, all_oe;
    logic [7:0] got, exp;
    logic [31:0] hdr;
    int total;
    total = (which != 0) ? TOT_B : TOT_A;
    sel = which;
    hdr = {op, addr};
    quiet = 1'b1;
    set_cs(which, 1'b0);
    repeat (HALF) @(negedge clk);
    for (int i = 31; i >= 0; i--) begin
      spi_bit(hdr[i], s, oe);
      if (oe) quiet = 1'b0;
    end
    if (op == 8'h0B)
      for (int i = 0; i < 8; i++) begin
        spi_bit(1'b1, s, oe);
        if (oe) quiet = 1'b0;
      end
    check(quiet, {tag, " R9 header quiet"}, 32'(quiet), 32'd1);
    for (int k = 0; k < n; k++) begin
      all_oe = 1'b1;
      for (int j = 7; j >= 0; j--) begin
        spi_bit(1'b0, s, oe);
        got[j] = s;
        if (!oe) all_oe = 1'b0;
      end
      exp = (which != 0) ? model_b[(start + k) % total] : model_a[(start + k) % total];
      check(got == exp && all_oe, $sformatf("%s byte %0d", tag, k), {23'd0, all_oe, got}, {24'd1, exp});
    end
    set_cs(which, 1'b1);
    repeat (4 * HALF) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic s, oe, quiet;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7 reset state
    check(!oe_a && !oe_b, "R7 reset enable low", {30'd0, oe_a, oe_b}, 32'd0);
    check(so_a == 1'b0, "R7 reset data low", 32'(so_a), 32'd0);

    // R10 fill both arrays through the write port
    for (int i = 0; i < TOT_A; i++) begin
      model_a[i] = pat(i);
      if (i < TOT_B) model_b[i] = pat(i);
      wa_a = 11'(i); wa_b = 10'(i); wd = pat(i);
      we_a = 1'b1; we_b = (i < TOT_B);
      @(negedge clk);
    end
    we_a = 1'b0; we_b = 1'b0;
    @(negedge clk);

    for (int v = 0; v < 7; v++)
      do_read(0, VECS[v].op, VECS[v].addr, int'(VECS[v].n), int'(VECS[v].start),
              $sformatf("R1 R2 R3 R5 R6 vector %0d", v));

    // R4 flat layout, R6 wrap in flat layout
    do_read(1, 8'h03, 24'h000305, 3, 773, "R4 flat slow");
    do_read(1, 8'h0B, 24'hFFFFFE, 3, 1022, "R4 R6 flat fast wrap");
    do_read(1, 8'h03, 24'h0000FE, 3, 254, "R5 flat page cross");

    // R8 unknown opcode keeps the pin released
    sel = 0; quiet = 1'b1;
    cs_a = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < 56; i++) begin
      spi_bit((i < 8) ? ((8'h9F >> (7 - i)) & 1'b1) : 1'b0, s, oe);
      if (oe) quiet = 1'b0;
    end
    check(quiet, "R8 bad opcode silent", 32'(quiet), 32'd1);
    cs_a = 1'b1;
    repeat (4 * HALF) @(negedge clk);

    // R7 abort mid-byte, then a fresh command
    cs_a = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 31; i >= 0; i--) spi_bit(((32'h03000205 >> i) & 1) != 0, s, oe);
    for (int i = 0; i < 3; i++) spi_bit(1'b0, s, oe);
    check(oe == 1'b1, "R7 driving before abort", 32'(oe), 32'd1);
    cs_a = 1'b1;
    repeat (5) @(negedge clk);
    check(oe_a == 1'b0, "R7 released after abort", 32'(oe_a), 32'd0);
    repeat (2 * HALF) @(negedge clk);
    do_read(0, 8'h03, 24'h000400, 2, 528, "R7 read after abort");

    // R10 overwrite one byte, read it back with its neighbour
    @(negedge clk);
    wa_a = 11'd700; wd = 8'h5A; we_a = 1'b1; model_a[700] = 8'h5A;
    @(negedge clk);
    we_a = 1'b0;
    do_read(0, 8'h03, 24'h0004AC, 2, 700, "R10 write then read");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule